// File: doc/BRIEF.md
# Pseudo-SRAM Access Controller

This block lets a synchronous host reach an asynchronous 1M x 16 pseudo-SRAM. The host raises a request with a 20-bit word address, a read/write flag, 16-bit write data and a two-bit lane mask. The controller latches them, runs one strobe sequence on the memory pins and returns a single-cycle acknowledge. A read also returns a single-cycle data-valid pulse with the captured word. Each strobe width and margin is a count of system clocks. The count is computed as the nanosecond limit divided by the clock period, rounded up.

A separate level input asks for deep power down. The controller accepts it only when no access is in progress. It then drives the active-high power control pin low. When the host drops the level, the pin returns high and a wake-up count must run out before any new access starts. Memory outputs are registered, so the pins move one clock after the internal sequencer.

Top module: `psram_ctrl`

## Requirements
- R1: A write holds chip enable low and output enable high for the whole cycle. Write enable is low for exactly 12 clocks, the longest of the 50 ns pulse, the 60 ns address-to-end and the 30 ns data-to-end limits at 5 ns per clock. Afterwards only the enabled lanes of the word hold the new data.
- R2: A read holds chip enable low and write enable high. Output enable goes low one clock after chip enable and stays low to the end of the cycle. The word is sampled on the last clock of the access count.
- R3: Lane mask bit 0 selects data bits 7:0 and the lower strobe, and bit 1 selects bits 15:8 and the upper strobe. On a read, the result lanes that are not enabled return zero.
- R4: An access with a lane mask of 00 completes with an acknowledge, keeps both byte strobes high throughout and leaves memory unchanged.
- R5: The data bus is driven only while write enable is low. The address stays constant while chip enable is low.
- R6: Output enable never falls while the data bus is driven, and never in the clock right after it was driven.
- R7: Chip enable stays low for exactly 14 clocks, which covers the 70 ns cycle time. The acknowledge is one clock wide. It arrives 16 clocks after the request is set up on the falling edge before the accepting rising edge.
- R8: The data-valid pulse occurs only for reads, coincides with the acknowledge and lasts one clock.
- R9: With the sleep level high and the controller idle, the power pin is driven low and chip enable stays high. No request is acknowledged while asleep.
- R10: After the sleep level drops, the power pin is high two clocks later. A pending request is acknowledged 57 clocks after the drop: 40 wake clocks for 200 ns, 14 access clocks and 3 clocks of pipeline.
- R11: During reset, every active-low strobe is high, the power pin is high, the bus is not driven, and both the acknowledge and the data-valid pulse are low.
- R12: A request and a sleep level that arrive in the same idle clock are handled access first, and power down follows that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_req | input | 1 | Access request, held until acknowledge |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | 20 | Word address |
| host_wdata | input | 16 | Write data |
| host_lanes | input | 2 | Lane enables, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| host_sleep | input | 1 | Deep power down level |
| host_ack | output | 1 | One-clock access completion |
| host_rvalid | output | 1 | One-clock read data valid |
| host_rdata | output | 16 | Read data, disabled lanes zero |
| mem_addr | output | 20 | Memory address bus |
| mem_dq_o | output | 16 | Data toward memory |
| mem_dq_i | input | 16 | Data from memory |
| mem_dq_oe | output | 1 | Drive enable for the data bus |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_pwr_on | output | 1 | Power control, low = deep power down |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_lb_n | output | 1 | Lower byte strobe, active low |
| mem_ub_n | output | 1 | Upper byte strobe, active low |

## Verification
The assertions assume the host keeps a request and its fields steady until the acknowledge. They also assume the host never raises a request in the same cycle it drops one. The bench keeps to this by driving inputs on falling edges and dropping the request as soon as the acknowledge is seen. A memory model in the bench enforces the nanosecond rules as clock counts. It returns a poison word when read too early and commits a write only when the strobe, address and data windows were met. Random addresses come from a small pool so that reads often hit words that were written earlier.

// File: rtl/psram_pkg.sv
`timescale 1ns/1ps
// Package: shared state type and timing helpers for the pseudo-SRAM controller.
// Assumes all timing limits are whole nanoseconds and the clock period is nonzero.
package psram_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACCESS = 2'd1,
        ST_SLEEP  = 2'd2,
        ST_WAKE   = 2'd3
    } ctrl_state_e;

    // Clocks needed to cover a time limit, rounded up.
    function automatic int unsigned cycles_for(input int unsigned ns, input int unsigned clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/psram_seq.sv
`timescale 1ns/1ps
// Module: psram_seq
// Sequencer for the controller: idle, access, sleep and wake states with a
// shared cycle counter. An access runs counter values 0..TOT_CYC. The last
// value is the finish clock, on which strobes release and data is sampled.
// Assumes host_req is held until acknowledged. A request wins over sleep in idle.
module psram_seq
    import psram_pkg::*;
#(
    parameter int unsigned TOT_CYC  = 14,
    parameter int unsigned WAKE_CYC = 40,
    parameter int unsigned CNT_W    = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             sleep,
    output ctrl_state_e      state,
    output logic [CNT_W-1:0] cnt,
    output logic             accept,
    output logic             finish
);

    localparam logic [CNT_W-1:0] LAST_ACC  = CNT_W'(TOT_CYC);
    localparam logic [CNT_W-1:0] LAST_WAKE = CNT_W'(WAKE_CYC - 1);

    assign accept = (state == ST_IDLE) && req;
    assign finish = (state == ST_ACCESS) && (cnt == LAST_ACC);

    // State and counter advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    cnt <= '0;
                    if (req)
                        state <= ST_ACCESS;
                    else if (sleep)
                        state <= ST_SLEEP;
                end
                ST_ACCESS: begin
                    if (cnt == LAST_ACC) begin
                        state <= ST_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_SLEEP: begin
                    cnt <= '0;
                    if (!sleep)
                        state <= ST_WAKE;
                end
                default: begin
                    if (cnt == LAST_WAKE) begin
                        state <= ST_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            endcase
        end
    end

    // R12: a request seen in idle always starts an access, even with sleep high.
    a_r12_req_before_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && req) |=> (state == ST_ACCESS));

    // R10: no access may start straight out of the wake window.
    a_r10_wake_no_access: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAKE) |=> (state != ST_ACCESS));

    // R9: sleep is entered only from idle.
    a_r9_sleep_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLEEP) |-> ($past(state) == ST_IDLE || $past(state) == ST_SLEEP));

endmodule

// File: rtl/psram_strobe_decode.sv
`timescale 1ns/1ps
// Module: psram_strobe_decode
// Combinational decode of the next value of every memory control pin from the
// sequencer state, counter and latched operation. The top registers these values.
// Assumes cnt counts from 0 on the first access clock.
module psram_strobe_decode
    import psram_pkg::*;
#(
    parameter int unsigned TOT_CYC = 14,
    parameter int unsigned WEL_CYC = 12,
    parameter int unsigned LANES   = 2,
    parameter int unsigned CNT_W   = 6
) (
    input  ctrl_state_e      state,
    input  logic [CNT_W-1:0] cnt,
    input  logic             op_write,
    input  logic [LANES-1:0] op_lanes,
    output logic             nx_ce_n,
    output logic             nx_pwr_on,
    output logic             nx_oe_n,
    output logic             nx_we_n,
    output logic             nx_dq_oe,
    output logic [LANES-1:0] nx_lane_n
);

    localparam logic [CNT_W-1:0] TOT_C = CNT_W'(TOT_CYC);
    localparam logic [CNT_W-1:0] WEL_C = CNT_W'(WEL_CYC);

    logic active;
    logic we_win;
    logic oe_win;

    // Window decode: chip active, write pulse window and read output window.
    always_comb begin
        active = (state == ST_ACCESS) && (cnt < TOT_C);
        we_win = active && op_write && (cnt < WEL_C);
        oe_win = active && !op_write && (cnt != '0);
    end

    // Pin values derived from the windows.
    always_comb begin
        nx_ce_n   = !active;
        nx_pwr_on = (state != ST_SLEEP);
        nx_we_n   = !we_win;
        nx_dq_oe  = we_win;
        nx_oe_n   = !oe_win;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Lane strobe low only during an active cycle with its mask bit set.
        always_comb nx_lane_n[g] = !(active && op_lanes[g]);
    end

endmodule

// File: rtl/psram_read_capture.sv
`timescale 1ns/1ps
// Module: psram_read_capture
// Samples the memory data bus on the finish clock of a read, zeroes lanes that
// were not enabled and raises a one-clock valid pulse.
// Assumes finish lasts exactly one clock per access.
module psram_read_capture #(
    parameter int unsigned LANES  = 2,
    parameter int unsigned LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    finish,
    input  logic                    op_write,
    input  logic [LANES-1:0]        op_lanes,
    input  logic [LANES*LANE_W-1:0] dq_in,
    output logic                    rvalid,
    output logic [LANES*LANE_W-1:0] rdata
);

    // Valid pulse for reads only.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rvalid <= 1'b0;
        else
            rvalid <= finish && !op_write;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_cap
        // Per-lane sample with masking of disabled lanes.
        always_ff @(posedge clk) begin
            if (!rst_n)
                rdata[g*LANE_W +: LANE_W] <= '0;
            else if (finish && !op_write)
                rdata[g*LANE_W +: LANE_W] <= op_lanes[g] ? dq_in[g*LANE_W +: LANE_W] : '0;
        end
    end

    // R8: valid is a single-clock pulse.
    a_r8_rvalid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |=> !rvalid);

endmodule

// File: rtl/psram_ctrl.sv
`timescale 1ns/1ps
// Module: psram_ctrl (top)
// Synchronous controller for an asynchronous pseudo-SRAM. It latches one host
// request, runs a counted strobe sequence on registered memory pins, then
// acknowledges. It also handles deep power down with a wake-up window.
// Assumes the host holds request fields stable until the acknowledge and that
// every timing limit is covered by rounding up to whole clocks.
module psram_ctrl
    import psram_pkg::*;
#(
    parameter int unsigned ADDR_W    = 20,
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned CLK_NS    = 5,
    parameter int unsigned T_RC_NS   = 70,
    parameter int unsigned T_AA_NS   = 70,
    parameter int unsigned T_OE_NS   = 35,
    parameter int unsigned T_WP_NS   = 50,
    parameter int unsigned T_AW_NS   = 60,
    parameter int unsigned T_DW_NS   = 30,
    parameter int unsigned T_WAKE_NS = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_write,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic [1:0]        host_lanes,
    input  logic              host_sleep,
    output logic              host_ack,
    output logic              host_rvalid,
    output logic [DATA_W-1:0] host_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_o,
    input  logic [DATA_W-1:0] mem_dq_i,
    output logic              mem_dq_oe,
    output logic              mem_ce_n,
    output logic              mem_pwr_on,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic              mem_lb_n,
    output logic              mem_ub_n
);

    localparam int unsigned LANE_W   = 8;
    localparam int unsigned LANES    = DATA_W / LANE_W;
    localparam int unsigned RC_CYC   = cycles_for(T_RC_NS, CLK_NS);
    localparam int unsigned AA_CYC   = cycles_for(T_AA_NS, CLK_NS);
    localparam int unsigned OE_CYC   = cycles_for(T_OE_NS, CLK_NS);
    localparam int unsigned WEL_CYC  = max2(cycles_for(T_WP_NS, CLK_NS),
                                       max2(cycles_for(T_AW_NS, CLK_NS),
                                            cycles_for(T_DW_NS, CLK_NS)));
    localparam int unsigned TOT_CYC  = max2(max2(RC_CYC, AA_CYC),
                                            max2(OE_CYC + 1, WEL_CYC + 1));
    localparam int unsigned WAKE_CYC = max2(cycles_for(T_WAKE_NS, CLK_NS), 1);
    localparam int unsigned CNT_W    = $clog2(max2(TOT_CYC, WAKE_CYC) + 1);

    ctrl_state_e             state;
    logic [CNT_W-1:0]        cnt;
    logic                    accept;
    logic                    finish;

    logic [ADDR_W-1:0]       addr_q;
    logic [DATA_W-1:0]       wdata_q;
    logic [LANES-1:0]        lanes_q;
    logic                    write_q;

    logic                    nx_ce_n, nx_pwr_on, nx_oe_n, nx_we_n, nx_dq_oe;
    logic [LANES-1:0]        nx_lane_n;
    logic [LANES-1:0]        lane_n_q;
    logic [LANES-1:0]        host_lane_vec;

    assign host_lane_vec = LANES'(host_lanes);

    psram_seq #(
        .TOT_CYC (TOT_CYC),
        .WAKE_CYC(WAKE_CYC),
        .CNT_W   (CNT_W)
    ) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (host_req),
        .sleep (host_sleep),
        .state (state),
        .cnt   (cnt),
        .accept(accept),
        .finish(finish)
    );

    // Latch the request fields when an access is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            lanes_q <= '0;
            write_q <= 1'b0;
        end else if (accept) begin
            addr_q  <= host_addr;
            wdata_q <= host_wdata;
            lanes_q <= host_lane_vec;
            write_q <= host_write;
        end
    end

    psram_strobe_decode #(
        .TOT_CYC(TOT_CYC),
        .WEL_CYC(WEL_CYC),
        .LANES  (LANES),
        .CNT_W  (CNT_W)
    ) u_dec (
        .state    (state),
        .cnt      (cnt),
        .op_write (write_q),
        .op_lanes (lanes_q),
        .nx_ce_n  (nx_ce_n),
        .nx_pwr_on(nx_pwr_on),
        .nx_oe_n  (nx_oe_n),
        .nx_we_n  (nx_we_n),
        .nx_dq_oe (nx_dq_oe),
        .nx_lane_n(nx_lane_n)
    );

    // Register every memory pin so the strobes come straight from flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_ce_n   <= 1'b1;
            mem_pwr_on <= 1'b1;
            mem_oe_n   <= 1'b1;
            mem_we_n   <= 1'b1;
            mem_dq_oe  <= 1'b0;
            lane_n_q   <= '1;
            mem_addr   <= '0;
            mem_dq_o   <= '0;
        end else begin
            mem_ce_n   <= nx_ce_n;
            mem_pwr_on <= nx_pwr_on;
            mem_oe_n   <= nx_oe_n;
            mem_we_n   <= nx_we_n;
            mem_dq_oe  <= nx_dq_oe;
            lane_n_q   <= nx_lane_n;
            mem_addr   <= addr_q;
            mem_dq_o   <= wdata_q;
        end
    end

    assign mem_lb_n = lane_n_q[0];
    assign mem_ub_n = lane_n_q[LANES-1];

    // Acknowledge on the clock the strobes release.
    always_ff @(posedge clk) begin
        if (!rst_n)
            host_ack <= 1'b0;
        else
            host_ack <= finish;
    end

    psram_read_capture #(
        .LANES (LANES),
        .LANE_W(LANE_W)
    ) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .finish  (finish),
        .op_write(write_q),
        .op_lanes(lanes_q),
        .dq_in   (mem_dq_i),
        .rvalid  (host_rvalid),
        .rdata   (host_rdata)
    );

    // Length of the current write-enable low run, used by the width check.
    logic [CNT_W-1:0] we_run;
    always_ff @(posedge clk) begin
        if (!rst_n)
            we_run <= '0;
        else if (!mem_we_n)
            we_run <= we_run + 1'b1;
        else
            we_run <= '0;
    end

    // R1: write pulse lasts exactly the computed clock count.
    a_r1_we_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (we_run == CNT_W'(WEL_CYC)));

    // R1: during a write the chip is enabled and output enable is held high.
    a_r1_write_pins: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_ce_n && mem_oe_n && mem_pwr_on));

    // R5: data bus driven only inside the write pulse.
    a_r5_drive_in_we: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> !mem_we_n);

    // R5: address stable while chip enable stays low.
    a_r5_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

    // R6: no bus contention.
    a_r6_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);

    // R6: output enable falls only after one clock with the bus released.
    a_r6_oe_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_oe_n) |-> (!$past(mem_dq_oe) && !$past(mem_ce_n)));

    // R7: acknowledge is one clock wide and coincides with chip enable release.
    a_r7_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |=> !host_ack);
    a_r7_ack_release: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |-> ($rose(mem_ce_n)));

    // R8: read valid only together with an acknowledge.
    a_r8_rvalid_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
        host_rvalid |-> host_ack);

    // R9: chip disabled whenever the power pin is low.
    a_r9_sleep_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_pwr_on |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe));

endmodule

// File: tb/tb_psram_ctrl.sv
`timescale 1ns/1ps
module tb_psram_ctrl;

    localparam int TOT  = 14;   // 70 ns at 5 ns
    localparam int WEL  = 12;   // max(50,60,30) ns at 5 ns
    localparam int WAKE = 40;   // 200 ns at 5 ns

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0, host_write = 1'b0, host_sleep = 1'b0;
    logic [19:0] host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic [1:0]  host_lanes = '0;
    logic        host_ack, host_rvalid;
    logic [15:0] host_rdata;
    logic [19:0] mem_addr;
    logic [15:0] mem_dq_o, mem_dq_i;
    logic        mem_dq_oe, mem_ce_n, mem_pwr_on, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n;

    always #2.5 clk = ~clk;

    psram_ctrl dut (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_write(host_write),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_lanes(host_lanes),
        .host_sleep(host_sleep), .host_ack(host_ack), .host_rvalid(host_rvalid),
        .host_rdata(host_rdata), .mem_addr(mem_addr), .mem_dq_o(mem_dq_o),
        .mem_dq_i(mem_dq_i), .mem_dq_oe(mem_dq_oe), .mem_ce_n(mem_ce_n),
        .mem_pwr_on(mem_pwr_on), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n)
    );

    int compared = 0;
    int mismatched = 0;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // ---------------- behavioural memory with timing rules ----------------
    logic [15:0] mmem   [logic [19:0]];
    logic [15:0] refmem [logic [19:0]];
    int ce_cnt = 0, oe_cnt = 0, we_cnt = 0, dq_cnt = 0;
    int last_ce_w = 0, last_we_w = 0, viol = 0;
    logic [19:0] ce_addr = '0;
    logic [15:0] last_dq = '0;
    logic w_lb = 0, w_ub = 0;
    bit lane_seen = 0;

    function automatic logic [15:0] rd_word(input logic [19:0] a);
        if (mmem.exists(a)) return mmem[a];
        return 16'h0000;
    endfunction

    function automatic logic [15:0] ref_word(input logic [19:0] a);
        if (refmem.exists(a)) return refmem[a];
        return 16'h0000;
    endfunction

    always_comb begin
        if (!mem_ce_n && !mem_oe_n && mem_we_n && ce_cnt >= 14 && oe_cnt >= 7)
            mem_dq_i = {mem_ub_n ? 8'h00 : rd_word(mem_addr)[15:8],
                        mem_lb_n ? 8'h00 : rd_word(mem_addr)[7:0]};
        else
            mem_dq_i = 16'hDEAD;
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (!mem_lb_n || !mem_ub_n) lane_seen = 1;
            if (mem_dq_oe && !mem_oe_n) begin viol++; $display("model: contention"); end
            if (mem_dq_oe && mem_we_n)  begin viol++; $display("model: drive outside write"); end
            if (!mem_pwr_on && !mem_ce_n) begin viol++; $display("model: access while asleep"); end
            // write tracking
            if (!mem_we_n) begin
                if (mem_ce_n) begin viol++; $display("model: write without chip enable"); end
                if (we_cnt > 0 && mem_dq_oe && mem_dq_o == last_dq) dq_cnt++;
                else dq_cnt = mem_dq_oe ? 1 : 0;
                last_dq = mem_dq_o;
                w_lb = !mem_lb_n;
                w_ub = !mem_ub_n;
                we_cnt++;
            end else if (we_cnt != 0) begin
                if (we_cnt >= 10 && dq_cnt >= 6 && ce_cnt >= 12) begin
                    logic [15:0] w;
                    w = rd_word(ce_addr);
                    if (w_lb) w[7:0]  = last_dq[7:0];
                    if (w_ub) w[15:8] = last_dq[15:8];
                    mmem[ce_addr] = w;
                end else begin
                    viol++;
                    $display("model: write window short we=%0d dq=%0d ce=%0d", we_cnt, dq_cnt, ce_cnt);
                end
                last_we_w = we_cnt;
                we_cnt = 0;
            end
            // chip enable and output enable tracking
            if (!mem_ce_n) begin
                if (ce_cnt == 0) ce_addr = mem_addr;
                else if (mem_addr != ce_addr) begin viol++; $display("model: address moved"); end
                ce_cnt++;
            end else begin
                if (ce_cnt != 0) last_ce_w = ce_cnt;
                ce_cnt = 0;
            end
            if (!mem_ce_n && !mem_oe_n) oe_cnt++; else oe_cnt = 0;
        end
    end

    // ---------------- watchdog ----------------
    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    // ---------------- bench helpers ----------------
    function automatic logic [15:0] exp_read(input logic [19:0] a, input logic [1:0] ln);
        logic [15:0] w;
        w = ref_word(a);
        return {ln[1] ? w[15:8] : 8'h00, ln[0] ? w[7:0] : 8'h00};
    endfunction

    task automatic ref_write(input logic [19:0] a, input logic [15:0] d, input logic [1:0] ln);
        logic [15:0] w;
        w = ref_word(a);
        if (ln[0]) w[7:0]  = d[7:0];
        if (ln[1]) w[15:8] = d[15:8];
        refmem[a] = w;
    endtask

    task automatic do_op(input bit wr, input logic [19:0] a, input logic [15:0] d,
                         input logic [1:0] ln, output logic [15:0] rd,
                         output int lat, output bit saw_rv);
        host_write = wr; host_addr = a; host_wdata = d; host_lanes = ln; host_req = 1'b1;
        lat = 0; saw_rv = 0; rd = '0;
        do begin
            @(negedge clk);
            lat++;
            if (host_rvalid) begin saw_rv = 1; rd = host_rdata; end
        end while (!host_ack && lat < 300);
        host_req = 1'b0;
        if (wr) ref_write(a, d, ln);
        @(negedge clk);
        check(host_ack == 1'b0, "R7 ack one clock", {31'd0, host_ack}, 32'd0);
    endtask

    logic [19:0] pool [8];

    initial begin
        logic [15:0] rd;
        int lat;
        bit rv;
        void'($urandom(32'd2024));
        for (int i = 0; i < 8; i++) pool[i] = 20'($urandom);

        // R11: reset state
        repeat (3) @(negedge clk);
        check({mem_ce_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n, mem_pwr_on} == 6'h3F,
              "R11 strobes idle in reset", {26'd0, mem_ce_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n, mem_pwr_on}, 32'h3F);
        check(!mem_dq_oe && !host_ack && !host_rvalid, "R11 bus and handshake low",
              {29'd0, mem_dq_oe, host_ack, host_rvalid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R7: full word write
        do_op(1, 20'hABCDE, 16'h1234, 2'b11, rd, lat, rv);
        check(lat == TOT + 2, "R7 write ack latency", lat, TOT + 2);
        check(last_ce_w == TOT, "R7 chip enable width", last_ce_w, TOT);
        check(last_we_w == WEL, "R1 write pulse width", last_we_w, WEL);
        check(!rv, "R8 no valid on write", {31'd0, rv}, 32'd0);
        check(rd_word(20'hABCDE) == 16'h1234, "R1 word stored", rd_word(20'hABCDE), 32'h1234);

        // R2 R8: full word read
        do_op(0, 20'hABCDE, 16'h0, 2'b11, rd, lat, rv);
        check(rv, "R8 valid on read", {31'd0, rv}, 32'd1);
        check(rd == 16'h1234, "R2 word read", rd, 32'h1234);
        check(lat == TOT + 2, "R7 read ack latency", lat, TOT + 2);

        // R3: lane writes and reads
        do_op(1, 20'hABCDE, 16'hFF77, 2'b01, rd, lat, rv);
        check(rd_word(20'hABCDE) == 16'h1277, "R3 lower lane write", rd_word(20'hABCDE), 32'h1277);
        do_op(1, 20'hABCDE, 16'h99EE, 2'b10, rd, lat, rv);
        check(rd_word(20'hABCDE) == 16'h9977, "R3 upper lane write", rd_word(20'hABCDE), 32'h9977);
        do_op(0, 20'hABCDE, 16'h0, 2'b01, rd, lat, rv);
        check(rd == 16'h0077, "R3 lower lane read", rd, 32'h0077);
        do_op(0, 20'hABCDE, 16'h0, 2'b10, rd, lat, rv);
        check(rd == 16'h9900, "R3 upper lane read", rd, 32'h9900);

        // R4: empty mask
        lane_seen = 0;
        do_op(1, 20'hABCDE, 16'h5555, 2'b00, rd, lat, rv);
        check(!lane_seen, "R4 no strobe with empty mask", {31'd0, lane_seen}, 32'd0);
        check(lat == TOT + 2, "R4 empty access acked", lat, TOT + 2);
        do_op(0, 20'hABCDE, 16'h0, 2'b11, rd, lat, rv);
        check(rd == 16'h9977, "R4 memory unchanged", rd, 32'h9977);

        // R9: power down
        host_sleep = 1'b1;
        repeat (3) @(negedge clk);
        check(!mem_pwr_on && mem_ce_n, "R9 power pin low", {30'd0, mem_pwr_on, mem_ce_n}, 32'd1);
        host_write = 1; host_addr = 20'h00042; host_wdata = 16'hC0DE; host_lanes = 2'b11; host_req = 1'b1;
        begin
            int acks = 0;
            for (int i = 0; i < 20; i++) begin @(negedge clk); if (host_ack) acks++; end
            check(acks == 0, "R9 request held off while asleep", acks, 0);
        end
        // R10: wake
        host_sleep = 1'b0;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
            if (lat == 2) check(mem_pwr_on, "R10 power pin back high", {31'd0, mem_pwr_on}, 32'd1);
        end while (!host_ack && lat < 300);
        host_req = 1'b0;
        ref_write(20'h00042, 16'hC0DE, 2'b11);
        check(lat == WAKE + TOT + 3, "R10 wake latency", lat, WAKE + TOT + 3);
        @(negedge clk);
        do_op(0, 20'h00042, 16'h0, 2'b11, rd, lat, rv);
        check(rd == 16'hC0DE, "R10 write after wake stored", rd, 32'hC0DE);

        // R12: request and sleep in the same idle clock
        host_sleep = 1'b1;
        do_op(0, 20'h00042, 16'h0, 2'b11, rd, lat, rv);
        check(lat == TOT + 2, "R12 access served first", lat, TOT + 2);
        check(rd == 16'hC0DE, "R12 read data", rd, 32'hC0DE);
        @(negedge clk);
        check(!mem_pwr_on, "R12 power down follows", {31'd0, mem_pwr_on}, 32'd0);
        host_sleep = 1'b0;
        repeat (WAKE + 4) @(negedge clk);

        // Random mix (R1 R2 R3 R5 R6)
        for (int n = 0; n < 300; n++) begin
            bit wr;
            logic [19:0] a;
            logic [15:0] d;
            logic [1:0] ln;
            logic [15:0] e;
            wr = 1'($urandom);
            a  = pool[$urandom_range(0, 7)];
            d  = 16'($urandom);
            ln = 2'($urandom);
            e  = exp_read(a, ln);
            do_op(wr, a, d, ln, rd, lat, rv);
            if (!wr) check(rd == e, "R2 R3 random read", rd, e);
            else     check(!rv, "R8 random write no valid", {31'd0, rv}, 32'd0);
        end

        // R5 R6: model-observed timing and bus rules
        check(viol == 0, "R5 R6 memory model rules", viol, 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule